// File: doc/BRIEF.md
# Dual-Rail Word Codec with Completion Tree

This block moves an n-bit word across a delay-insensitive link. Every data bit travels on its own wire pair. When both wires are low the pair carries no data. The low wire high means a zero, and the high wire high means a one. A transfer follows a four-phase, return-to-zero pattern. The sender raises every pair to a valid code, the receiver sees the whole word complete, and then all pairs drop back to the empty code before the next word may start.

The transmit side takes a word on a level request and puts the encoded pairs on `tx_rail`. It holds them until the request drops, and then drives every pair to empty. The receive side watches `rx_rail`. Each pair reports its own validity with no separate strobe. A tree of clocked Muller C-element nodes merges the per-pair validity into `rx_done`. That output rises only once every pair is valid and falls only once every pair is empty. Between those two points it keeps its value. The decoded word is captured when completion rises. A pair showing both wires high is illegal and raises a flag that stays set until reset.

With `DATA_W`=8 and `FAN_IN`=4, the tree has two levels, so completion trails the rails by two clock cycles.

Top module: `dr_codec`

## Requirements
- R1: While `rst_n` is low, `tx_rail` is all zero, `rx_done` is 0, `rx_word` is 0 and `rx_err` is 0.
- R2: Pair i of `tx_rail` is bits 2i+1 (true wire) and 2i (false wire). One cycle after `tx_req` is seen high with the encoder empty, each pair reads 2'b10 for a word bit of 1 and 2'b01 for a 0. 2'b11 is never driven.
- R3: While `tx_req` stays high, `tx_rail` keeps the word captured at the request, whatever `tx_word` does.
- R4: One cycle after `tx_req` is seen low, `tx_rail` is all zero. A new word is accepted only after such a return to all-empty.
- R5: `rx_done` rises exactly LEVELS cycles after every pair of `rx_rail` became valid (01 or 10), where LEVELS = ceil(log_FAN_IN(DATA_W)) and is 2 by default.
- R6: Once high, `rx_done` stays high while any pair is still valid, and falls exactly LEVELS cycles after every pair has become 00.
- R7: While only some pairs are valid and the rest are 00, `rx_done` stays 0.
- R8: `rx_word` takes the decoded word (bit i = 1 for pair 10, 0 for pair 01) one cycle after `rx_done` rises. It holds that value while `rx_done` stays high, even if the rails change, and keeps it after `rx_done` falls until the next rise.
- R9: One cycle after any pair of `rx_rail` reads 2'b11, `rx_err` is 1, and it stays 1 until reset.
- R10: A pair reading 2'b11 does not count as valid, so a word that contains one never raises `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Level request: high sends `tx_word`, low returns the link to empty |
| tx_word | input | DATA_W | Binary word to send |
| tx_rail | output | 2*DATA_W | Encoded pairs driven to the link |
| rx_rail | input | 2*DATA_W | Pairs received from the link |
| rx_done | output | 1 | Completion: 1 when all pairs valid, 0 when all empty, hold otherwise |
| rx_word | output | DATA_W | Decoded word captured at completion |
| rx_err | output | 1 | Sticky flag for an illegal 11 pair |

## Verification
The hardest behaviour to reach is the hysteresis of the completion tree: a word that is only partly valid or only partly returned to empty must leave `rx_done` unchanged. The encoder never produces such states, so the bench disconnects the loopback and drives `rx_rail` directly. It drives half a word valid, then the full word, then a different valid word while completion is high, then half a release, and finally all-empty. It counts the cycles at each step so the exact rise and fall latency can be checked. An illegal pair is injected last, because the flag it raises only clears with reset.

// File: rtl/dr_pkg.sv
package dr_pkg;

  typedef enum logic {
    ENC_SPACER = 1'b0,
    ENC_DATA   = 1'b1
  } enc_state_e;

  // Smallest number of levels so that a**levels >= w, at least one.
  function automatic int tree_levels(input int w, input int a);
    int lv;
    int cap;
    lv  = 1;
    cap = a;
    while (cap < w) begin
      cap = cap * a;
      lv  = lv + 1;
    end
    return lv;
  endfunction

  function automatic int pow_i(input int b, input int e);
    int r;
    r = 1;
    for (int k = 0; k < e; k++) r = r * b;
    return r;
  endfunction

  // Index of the first node of level lv in the flat node vector.
  function automatic int node_off(input int nleaf, input int a, input int lv);
    int off;
    int cnt;
    off = 0;
    cnt = nleaf;
    for (int k = 0; k < lv; k++) begin
      off = off + cnt;
      cnt = cnt / a;
    end
    return off;
  endfunction

endpackage

// File: rtl/dr_cnode.sv
module dr_cnode #(
  parameter int FAN_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FAN_IN-1:0] in_bits,
  output logic              q
);

  logic all_hi;
  logic all_lo;

  assign all_hi = &in_bits;
  assign all_lo = ~|in_bits;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= 1'b0;
    else if (all_hi) q <= 1'b1;
    else if (all_lo) q <= 1'b0;
  end

endmodule

// File: rtl/dr_ctree.sv
module dr_ctree
  import dr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FAN_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] lane_valid,
  output logic              done
);

  localparam int LEVELS = tree_levels(DATA_W, FAN_IN);
  localparam int NLEAF  = pow_i(FAN_IN, LEVELS);
  localparam int TOTAL  = node_off(NLEAF, FAN_IN, LEVELS) + 1;

  wire [TOTAL-1:0] node;

  // Leaves: spare leaves repeat lane 0, which leaves the hysteresis unchanged.
  for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
    if (j < DATA_W) begin : g_real
      assign node[j] = lane_valid[j];
    end else begin : g_pad
      assign node[j] = lane_valid[0];
    end
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int CNT_IN  = NLEAF / pow_i(FAN_IN, lv);
    localparam int CNT_OUT = CNT_IN / FAN_IN;
    localparam int OFF_IN  = node_off(NLEAF, FAN_IN, lv);
    localparam int OFF_OUT = OFF_IN + CNT_IN;
    for (genvar n = 0; n < CNT_OUT; n++) begin : g_node
      dr_cnode #(.FAN_IN(FAN_IN)) u_node (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bits (node[OFF_IN + n*FAN_IN +: FAN_IN]),
        .q       (node[OFF_OUT + n])
      );
    end
  end

  assign done = node[TOTAL-1];

endmodule

// File: rtl/dr_encoder.sv
module dr_encoder
  import dr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_req,
  input  logic [DATA_W-1:0]   tx_word,
  output logic [2*DATA_W-1:0] tx_rail
);

  function automatic logic [2*DATA_W-1:0] word_to_rails(input logic [DATA_W-1:0] w);
    logic [2*DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) begin
      r[2*i+1] = w[i];
      r[2*i]   = ~w[i];
    end
    return r;
  endfunction

  enc_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ENC_SPACER;
      tx_rail <= '0;
    end else begin
      unique case (state)
        ENC_SPACER: if (tx_req) begin
          tx_rail <= word_to_rails(tx_word);
          state   <= ENC_DATA;
        end
        ENC_DATA: if (!tx_req) begin
          tx_rail <= '0;
          state   <= ENC_SPACER;
        end
        default: state <= ENC_SPACER;
      endcase
    end
  end

endmodule

// File: rtl/dr_decoder.sv
module dr_decoder #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] rx_rail,
  input  logic                done,
  input  logic [DATA_W-1:0]   lane_bad,
  output logic [DATA_W-1:0]   rx_word,
  output logic                rx_err
);

  function automatic logic [DATA_W-1:0] rails_to_word(input logic [2*DATA_W-1:0] r);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = r[2*i+1] & ~r[2*i];
    return w;
  endfunction

  logic done_q;
  logic done_rise;
  logic bad_seen;

  assign done_rise = done & ~done_q;
  assign bad_seen  = |lane_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rx_word <= '0;
      rx_err  <= 1'b0;
    end else begin
      done_q <= done;
      if (done_rise) rx_word <= rails_to_word(rx_rail);
      if (bad_seen)  rx_err  <= 1'b1;
    end
  end

endmodule

// File: rtl/dr_codec.sv
module dr_codec #(
  parameter int DATA_W = 8,
  parameter int FAN_IN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_req,
  input  logic [DATA_W-1:0]   tx_word,
  output logic [2*DATA_W-1:0] tx_rail,
  input  logic [2*DATA_W-1:0] rx_rail,
  output logic                rx_done,
  output logic [DATA_W-1:0]   rx_word,
  output logic                rx_err
);

  // A pair is valid when exactly one wire is high; both high is illegal.
  function automatic logic [DATA_W-1:0] pair_valid(input logic [2*DATA_W-1:0] r);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W; i++) v[i] = r[2*i+1] ^ r[2*i];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pair_bad(input logic [2*DATA_W-1:0] r);
    logic [DATA_W-1:0] b;
    for (int i = 0; i < DATA_W; i++) b[i] = r[2*i+1] & r[2*i];
    return b;
  endfunction

  logic [DATA_W-1:0] lane_valid;
  logic [DATA_W-1:0] lane_bad;

  assign lane_valid = pair_valid(rx_rail);
  assign lane_bad   = pair_bad(rx_rail);

  dr_encoder #(.DATA_W(DATA_W)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_req  (tx_req),
    .tx_word (tx_word),
    .tx_rail (tx_rail)
  );

  dr_ctree #(.DATA_W(DATA_W), .FAN_IN(FAN_IN)) u_tree (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_valid (lane_valid),
    .done       (rx_done)
  );

  dr_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_rail  (rx_rail),
    .done     (rx_done),
    .lane_bad (lane_bad),
    .rx_word  (rx_word),
    .rx_err   (rx_err)
  );

endmodule

// File: rtl/dr_codec_chk.sv
module dr_codec_chk
  import dr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FAN_IN = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tx_req,
  input logic [2*DATA_W-1:0] tx_rail,
  input logic [2*DATA_W-1:0] rx_rail,
  input logic                rx_done,
  input logic [DATA_W-1:0]   rx_word,
  input logic                rx_err
);

  localparam int LEVELS = tree_levels(DATA_W, FAN_IN);

  function automatic logic every_pair_valid(input logic [2*DATA_W-1:0] r);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DATA_W; i++) if (r[2*i+1] == r[2*i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic some_pair_bad(input logic [2*DATA_W-1:0] r);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < DATA_W; i++) if (r[2*i+1] && r[2*i]) hit = 1'b1;
    return hit;
  endfunction

  int valid_run;
  int spacer_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_run  <= 0;
      spacer_run <= 0;
    end else begin
      valid_run  <= every_pair_valid(rx_rail) ? ((valid_run < 1000) ? valid_run + 1 : valid_run) : 0;
      spacer_run <= (rx_rail == '0) ? ((spacer_run < 1000) ? spacer_run + 1 : spacer_run) : 0;
    end
  end

  p_enc_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !some_pair_bad(tx_rail));

  p_rtz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> (tx_rail == '0));

  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (valid_run >= LEVELS));

  p_done_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_done) |-> (spacer_run >= LEVELS));

  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && $past(rx_done)) |=> $stable(rx_word));

  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    some_pair_bad(rx_rail) |=> rx_err);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> rx_err);

endmodule

bind dr_codec dr_codec_chk #(.DATA_W(DATA_W), .FAN_IN(FAN_IN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_req  (tx_req),
  .tx_rail (tx_rail),
  .rx_rail (rx_rail),
  .rx_done (rx_done),
  .rx_word (rx_word),
  .rx_err  (rx_err)
);

// File: tb/test_dr_codec.sv
`timescale 1ns/1ps
module test_dr_codec;

  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tx_req = 1'b0;
  logic [W-1:0]   tx_word = '0;
  logic [2*W-1:0] tx_rail;
  logic [2*W-1:0] rx_rail;
  logic [2*W-1:0] inj_rail = '0;
  logic           use_loop = 1'b1;
  logic           rx_done;
  logic [W-1:0]   rx_word;
  logic           rx_err;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  assign rx_rail = use_loop ? tx_rail : inj_rail;

  dr_codec #(.DATA_W(W), .FAN_IN(4)) i_dr_codec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_req  (tx_req),
    .tx_word (tx_word),
    .tx_rail (tx_rail),
    .rx_rail (rx_rail),
    .rx_done (rx_done),
    .rx_word (rx_word),
    .rx_err  (rx_err)
  );

  // Expected pairs: bit one -> true wire (upper) high, bit zero -> false wire high.
  function automatic logic [2*W-1:0] exp_rails(input logic [W-1:0] w);
    logic [2*W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) r[2*i +: 2] = w[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: one cycle after completion is seen rising, compare the word.
  logic mon_prev = 1'b0;
  logic mon_arm  = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_prev = 1'b0;
      mon_arm  = 1'b0;
    end else begin
      if (mon_arm) begin
        mon_arm = 1'b0;
        if (exp_q.size() == 0) chk("R8 unexpected completion", 64'(rx_word), 64'hDEAD);
        else chk("R8 captured word", 64'(rx_word), 64'(exp_q.pop_front()));
      end
      if (rx_done && !mon_prev) mon_arm = 1'b1;
      mon_prev = rx_done;
    end
  end

  // Full loopback transfer through encoder, tree and decoder.
  task automatic send_word(input logic [W-1:0] w);
    tx_word = w;
    tx_req  = 1'b1;
    exp_q.push_back(w);
    step(1); chk("R2 encoded rails", 64'(tx_rail), 64'(exp_rails(w)));
    step(1); chk("R5 completion not early", 64'(rx_done), 64'd0);
    step(1); chk("R5 completion rise", 64'(rx_done), 64'd1);
    step(1);
    tx_req = 1'b0;
    step(1); chk("R4 spacer after release", 64'(tx_rail), 64'd0);
    step(1); chk("R6 completion holds", 64'(rx_done), 64'd1);
    step(1); chk("R6 completion fall", 64'(rx_done), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles=100000 expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [2*W-1:0] r;
    step(3);
    chk("R1 reset rails", 64'(tx_rail), 64'd0);
    chk("R1 reset done", 64'(rx_done), 64'd0);
    chk("R1 reset word", 64'(rx_word), 64'd0);
    chk("R1 reset err", 64'(rx_err), 64'd0);
    rst_n = 1'b1;
    step(2);

    send_word(8'hA5);
    send_word(8'h00);
    send_word(8'hFF);
    send_word(8'h3C);

    // R3 / R4: request held high, word changes, no new word until spacer.
    tx_word = 8'h96; tx_req = 1'b1; exp_q.push_back(8'h96);
    step(1); tx_word = 8'h69;
    step(2); chk("R3 word held while request high", 64'(tx_rail), 64'(exp_rails(8'h96)));
    step(2); chk("R4 no new word without spacer", 64'(tx_rail), 64'(exp_rails(8'h96)));
    tx_req = 1'b0;
    step(1); chk("R4 spacer before next word", 64'(tx_rail), 64'd0);
    step(3);
    tx_req = 1'b1; exp_q.push_back(8'h69);
    step(1); chk("R4 next word after spacer", 64'(tx_rail), 64'(exp_rails(8'h69)));
    step(4); tx_req = 1'b0;
    step(4);

    // Direct injection for partial states.
    use_loop = 1'b0;
    inj_rail = '0;
    r = exp_rails(8'h5A);
    inj_rail[7:0] = r[7:0];
    step(5); chk("R7 partial word keeps completion low", 64'(rx_done), 64'd0);
    inj_rail = exp_rails(8'h5A); exp_q.push_back(8'h5A);
    step(1); chk("R5 tree latency not early", 64'(rx_done), 64'd0);
    step(1); chk("R5 tree latency rise", 64'(rx_done), 64'd1);
    step(1);
    inj_rail = exp_rails(8'hC3);
    step(3); chk("R8 word held while complete", 64'(rx_word), 64'h5A);
    chk("R8 completion still high", 64'(rx_done), 64'd1);
    inj_rail[7:0] = 8'h00;
    step(5); chk("R6 partial spacer keeps completion high", 64'(rx_done), 64'd1);
    inj_rail = '0;
    step(1); chk("R6 fall not early", 64'(rx_done), 64'd1);
    step(1); chk("R6 fall latency", 64'(rx_done), 64'd0);
    step(2); chk("R8 word kept after fall", 64'(rx_word), 64'h5A);
    chk("R9 no error before illegal pair", 64'(rx_err), 64'd0);

    // Illegal pair in lane 2.
    r = exp_rails(8'h0F);
    r[5:4] = 2'b11;
    inj_rail = r;
    step(1); chk("R9 error raised", 64'(rx_err), 64'd1);
    step(5); chk("R10 illegal pair blocks completion", 64'(rx_done), 64'd0);
    inj_rail = '0;
    step(3); chk("R9 error sticky", 64'(rx_err), 64'd1);
    rst_n = 1'b0;
    step(2);
    chk("R1 reset clears err", 64'(rx_err), 64'd0);
    chk("R1 reset clears word", 64'(rx_word), 64'd0);
    chk("R8 scoreboard drained", 64'(exp_q.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule